// File: doc/BRIEF.md
# Register-Programmed Power-of-Two Clock Divider

This block makes one gated, divided copy of a crystal reference clock, meant to be routed out on a pin's alternate function. Software programs a 3-bit logarithmic divide code and a run bit through a byte-wide register port. The port has an offset, write data, a write strobe, a read strobe and registered read data. The output starts and stops only on whole periods, so it never emits a shortened high or low phase.

The divide code selects a ratio of 2^(code-1) for codes 2 to 7. Codes 0 and 1 both select the undivided reference clock, which passes through a glitch-free gate. The ratio is captured each time the output starts from the stopped state. A new code written while the output runs waits for the next start.

One instance drives one output. A wrapper that replicates it gives each copy its own 0x100-byte window, so only the low offset byte reaches the block. A read-only status bit shows whether the output is actually running.

Top module: `pow2_clock_divider`

## Requirements
- R1: After reset the divide code reads 0, the run bit reads 0, the status bit reads 0 and the output is low.
- R2: With a captured code c of 2 to 7, the output has a period of 2^(c-1) reference cycles. It starts with a high phase, and every high and every low phase lasts exactly 2^(c-2) cycles.
- R3: Codes 0 and 1 both select the undivided mode. In that mode the output equals the reference clock during whole reference periods and is otherwise low.
- R4: Once the run bit is stored, the output must be toggling within (2 + 3×div) reference cycles. In divided modes the first high phase begins on the next rising reference edge.
- R5: Once the run bit is cleared, the output finishes the period in progress, ends low and stops. It stops within 3×div reference cycles, and the status bit falls when it stops.
- R6: A divide code written while the output runs is stored and reads back at once, but the running ratio does not change until the output next starts from the stopped state.
- R7: Register layout within the window. Offset 0x43 holds the divide code in bits [2:0]. Offset 0x46 holds the run bit in bit 7 (1 = run). Offset 0x08 bit 7 is the read-only status (1 = toggling). Read data reflects the addressed register one cycle after a read strobe, holds while no read strobe is given, and has all other bits 0.
- R8: Reads of any other offset return 0x00. Writes to the status offset or to any other offset leave the divide code, the run bit and the output unchanged.
- R9: If the run bit is cleared and then set again before the current period ends, the output continues at the same ratio with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte offset within the channel window |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Registered read data |
| clk_div_out | output | 1 | Gated, divided clock output |

## Verification
The assertions rely on a few input conditions. Reset must stay low across at least one full reference period, so the falling-edge gate flop is cleared as well. The offset and write data must be defined whenever a strobe is high, and they must change only away from the rising reference edge. The bench meets these by driving every input on the falling edge and holding reset for five cycles. Its cycle reference model then checks the output at a quarter period after each rising edge, when the undivided gate shows its level. The stimulus deliberately writes the divide code while the output runs and toggles the run bit within a single period, because the block is specified to tolerate both.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants for the power-of-two clock divider.
// Assumes an 8-bit offset space per channel window.
package clkdiv_pkg;
    localparam logic [7:0] OFFS_CODE   = 8'h43;  // divide code register
    localparam logic [7:0] OFFS_RUN    = 8'h46;  // run-bit register
    localparam logic [7:0] OFFS_STATUS = 8'h08;  // read-only status
    localparam int         RUN_BIT     = 7;      // bit position of run and status flags
endpackage

// File: rtl/clkdiv_regs.sv
// Register file: stores the divide code and run bit, and returns registered read
// data. Assumes one-cycle strobes and an offset that is valid while a strobe is high.
module clkdiv_regs #(
    parameter int           ADDR_W      = 8,
    parameter int           DATA_W      = 8,
    parameter int           CODE_W      = 3,
    parameter int           RUN_BIT     = 7,
    parameter logic [7:0]   OFFS_CODE   = 8'h43,
    parameter logic [7:0]   OFFS_RUN    = 8'h46,
    parameter logic [7:0]   OFFS_STATUS = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic              running,
    output logic [DATA_W-1:0] rdata,
    output logic [CODE_W-1:0] code_q,
    output logic              run_q
);
    logic [DATA_W-1:0] rd_val;

    // Storage for the divide code and the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            run_q  <= 1'b0;
        end else if (wr) begin
            if (addr == ADDR_W'(OFFS_CODE)) code_q <= wdata[CODE_W-1:0];
            if (addr == ADDR_W'(OFFS_RUN))  run_q  <= wdata[RUN_BIT];
        end
    end

    // Read multiplexer; unimplemented bits and unknown offsets give zero.
    always_comb begin
        rd_val = '0;
        if (addr == ADDR_W'(OFFS_CODE))        rd_val[CODE_W-1:0] = code_q;
        else if (addr == ADDR_W'(OFFS_RUN))    rd_val[RUN_BIT]    = run_q;
        else if (addr == ADDR_W'(OFFS_STATUS)) rd_val[RUN_BIT]    = running;
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != ADDR_W'(OFFS_CODE) && addr != ADDR_W'(OFFS_RUN))
        |=> ($stable(code_q) && $stable(run_q)));
endmodule

// File: rtl/clkdiv_core.sv
// Sequencer and half-period counter. Captures the ratio when the output starts
// from the stopped state and stops only at the end of a low phase. Assumes the
// code is 0..2^CODE_W-1, with codes below 2 meaning the undivided mode.
module clkdiv_core #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [CODE_W-1:0] code_req,
    output logic              running,
    output logic              bypass,
    output logic              lvl
);
    localparam int MAX_SHIFT = (1 << CODE_W) - 3;            // log2 of the largest half period
    localparam int CNT_W     = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [CODE_W-1:0] act_code;
    logic [CNT_W-1:0]  half_cnt;
    logic [CNT_W-1:0]  half_m1;

    // Last count of a half period for the captured code.
    always_comb begin
        half_m1 = '0;
        if (act_code >= CODE_W'(2))
            half_m1 = CNT_W'((32'd1 << (32'(act_code) - 32'd2)) - 32'd1);
    end

    assign bypass = (act_code < CODE_W'(2));

    // Start, run and stop sequencing with whole-phase gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            act_code <= '0;
            half_cnt <= '0;
            lvl      <= 1'b0;
        end else if (!running) begin
            half_cnt <= '0;
            if (run_req) begin
                running  <= 1'b1;
                act_code <= code_req;
                lvl      <= (code_req >= CODE_W'(2));
            end
        end else if (bypass) begin
            if (!run_req) running <= 1'b0;
        end else if (half_cnt != half_m1) begin
            half_cnt <= half_cnt + 1'b1;
        end else begin
            half_cnt <= '0;
            if (lvl)          lvl     <= 1'b0;
            else if (!run_req) running <= 1'b0;
            else              lvl     <= 1'b1;
        end
    end

    // R4
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && run_req) |=> (running && act_code == $past(code_req)));

    // R5
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> !$past(lvl));

    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(act_code));

    // R2
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !bypass && half_cnt != half_m1) |=> $stable(lvl));
endmodule

// File: rtl/clkdiv_gate.sv
// Output stage: a falling-edge enable flop gates the raw reference clock in the
// undivided mode, and the divided level is OR-ed in. Assumes lvl stays low while
// the undivided mode is active.
module clkdiv_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic bypass,
    input  logic lvl,
    output logic clk_out
);
    logic gate_q;

    // Enable for the undivided path, changed only while the clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= running & bypass;
    end

    assign clk_out = (clk & gate_q) | lvl;

    // R3
    gate_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (bypass && !lvl));
endmodule

// File: rtl/pow2_clock_divider.sv
// Top: one divided-clock channel with its byte register port. Assumes the
// enclosing wrapper has already decoded the channel window, so only the low
// offset byte arrives here.
module pow2_clock_divider
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_div_out
);
    logic [CODE_W-1:0] code_q;
    logic              run_q;
    logic              running;
    logic              bypass;
    logic              lvl;

    clkdiv_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .RUN_BIT(RUN_BIT),
        .OFFS_CODE(OFFS_CODE), .OFFS_RUN(OFFS_RUN), .OFFS_STATUS(OFFS_STATUS)
    ) u_regs (
        .clk(clk_ref), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .wr(reg_wr), .rd(reg_rd), .running(running), .rdata(reg_rdata),
        .code_q(code_q), .run_q(run_q)
    );

    clkdiv_core #(.CODE_W(CODE_W)) u_core (
        .clk(clk_ref), .rst_n(rst_n), .run_req(run_q), .code_req(code_q),
        .running(running), .bypass(bypass), .lvl(lvl)
    );

    clkdiv_gate u_gate (
        .clk(clk_ref), .rst_n(rst_n), .running(running), .bypass(bypass),
        .lvl(lvl), .clk_out(clk_div_out)
    );
endmodule

// File: tb/pow2_clock_divider_test.sv
module pow2_clock_divider_test;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    wire  [7:0] reg_rdata;
    wire        clk_div_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    // behavioural reference state
    int m_en = 0, m_code = 0, m_run = 0, m_div = 1, m_pos = 0, m_byp = 0, m_rdata = 0;
    int o_en, o_code, o_run;
    int exp_out = 0;
    bit live = 0;

    pow2_clock_divider uut (
        .clk_ref(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .clk_div_out(clk_div_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    // Reference model stepped on each rising edge, compared a quarter period later.
    always @(posedge clk) begin
        live = rst_n;
        if (!rst_n) begin
            m_en = 0; m_code = 0; m_run = 0; m_div = 1; m_pos = 0; m_byp = 0; m_rdata = 0; exp_out = 0;
        end else begin
            o_en = m_en; o_code = m_code; o_run = m_run;
            if (reg_rd)
                m_rdata = (reg_addr == 8'h43) ? o_code :
                          (reg_addr == 8'h46) ? (o_en << 7) :
                          (reg_addr == 8'h08) ? (o_run << 7) : 0;
            if (!o_run) begin
                if (o_en != 0) begin
                    m_run = 1; m_div = (o_code < 2) ? 1 : (1 << (o_code - 1)); m_pos = 0;
                end
            end else if (m_div == 1) begin
                if (o_en == 0) m_run = 0;
            end else if (m_pos == m_div - 1) begin
                if (o_en == 0) m_run = 0; else m_pos = 0;
            end else begin
                m_pos++;
            end
            if (reg_wr && reg_addr == 8'h43) m_code = reg_wdata & 7;
            if (reg_wr && reg_addr == 8'h46) m_en = reg_wdata[7];
            exp_out = (m_run != 0 && m_div > 1) ? ((m_pos < m_div / 2) ? 1 : 0) : m_byp;
            m_byp = (m_run != 0 && m_div == 1) ? 1 : 0;
        end
        #(QTR);
        if (live) begin
            check(tag, 32'(clk_div_out), 32'(exp_out), "output level");
            check(tag, 32'(reg_rdata), 32'(m_rdata), "read data");
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string t);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0;
        check(t, 32'(reg_rdata), 32'(exp), "register read");
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Set the run bit and count edges until the output is seen high.
    task automatic start_meas(input int div, input string t);
        bit found = 0;
        int n = 0;
        wr_reg(8'h46, 8'h80);
        repeat (2 + 3 * div) begin
            if (!found) begin
                @(posedge clk); #(QTR); n++;
                if (clk_div_out === 1'b1) found = 1;
            end
        end
        check(t, 32'(found), 32'd1, "start within latency bound");
    endtask

    // Clear the run bit and poll status every cycle until it reads 0.
    task automatic stop_meas(input int div, input string t);
        bit stopped = 0;
        int n = 0;
        wr_reg(8'h46, 8'h00);
        reg_rd = 1'b1; reg_addr = 8'h08;
        repeat (3 * div + 2) begin
            if (!stopped) begin
                @(posedge clk); #(QTR); n++;
                if (reg_rdata[7] === 1'b0) stopped = 1;
            end
        end
        @(negedge clk); reg_rd = 1'b0;
        check(t, 32'(stopped && (n - 1) <= 3 * div), 32'd1, "stop within latency bound");
        check(t, 32'(clk_div_out), 32'd0, "output low after stop");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        // R1 reset state
        tag = "R1";
        check("R1", 32'(clk_div_out), 32'd0, "output after reset");
        rd_reg(8'h43, 8'h00, "R1");
        rd_reg(8'h46, 8'h00, "R1");
        rd_reg(8'h08, 8'h00, "R1");

        // R7 layout, unimplemented bits read 0
        tag = "R7";
        wr_reg(8'h43, 8'hFA);
        rd_reg(8'h43, 8'h02, "R7");

        // R4 start, R2 divide by 2
        tag = "R4";
        start_meas(2, "R4");
        tag = "R2";
        rd_reg(8'h46, 8'h80, "R7");
        rd_reg(8'h08, 8'h80, "R7");
        idle(20);

        // R6 code change while running
        tag = "R6";
        wr_reg(8'h43, 8'h04);
        rd_reg(8'h43, 8'h04, "R6");
        idle(16);
        tag = "R5";
        stop_meas(2, "R5");

        // R2 divide by 8 after restart
        tag = "R2";
        start_meas(8, "R2");
        idle(40);
        tag = "R5";
        stop_meas(8, "R5");

        // R2 largest ratio, divide by 64
        tag = "R2";
        wr_reg(8'h43, 8'h07);
        start_meas(64, "R2");
        idle(140);
        tag = "R5";
        stop_meas(64, "R5");

        // R3 undivided mode with code 0 and code 1
        tag = "R3";
        wr_reg(8'h43, 8'h00);
        start_meas(1, "R3");
        idle(10);
        stop_meas(1, "R3");
        wr_reg(8'h43, 8'h01);
        start_meas(1, "R3");
        idle(10);
        stop_meas(1, "R3");

        // R9 brief clear and re-set keeps the output running
        tag = "R9";
        wr_reg(8'h43, 8'h03);
        start_meas(4, "R9");
        idle(3);
        wr_reg(8'h46, 8'h00);
        wr_reg(8'h46, 8'h80);
        idle(20);

        // R8 stray writes and reads of undefined offsets
        tag = "R8";
        wr_reg(8'h08, 8'hFF);
        wr_reg(8'h50, 8'hFF);
        wr_reg(8'h44, 8'h00);
        rd_reg(8'h50, 8'h00, "R8");
        rd_reg(8'h44, 8'h00, "R8");
        rd_reg(8'h43, 8'h03, "R8");
        rd_reg(8'h46, 8'h80, "R8");
        idle(12);
        tag = "R5";
        stop_meas(4, "R5");
        idle(10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule